// File: doc/BRIEF.md
# SPI Register Command Slave for a CAN Controller

This block is the serial front end of a CAN controller. A host reaches the controller's byte-wide register space over SPI in mode 0 (clock idles low, data sampled on the rising edge, 8-bit words). Every transaction opens with one opcode byte while chip select is low. The opcodes are generic read and write, masked bit modify, soft reset, and shortcut opcodes. The shortcut opcodes load a transmit buffer or read a receive buffer from a fixed start address, so the host does not send an address byte.

A 128-byte register bank stands in for the CAN engine. It holds the mode request, a mode status that follows that request, and an interrupt enable/flag pair that drives an active-low interrupt pin. The SPI pins are synchronised into the system clock domain, so SCLK must be several times slower than `clk`.

Top module: `can_spi_cmd_slave`

## Requirements
- R1: After `rst_n` is released, and after the single-byte opcode 0xC0, every register reads 0x00 except two. Control (0x0F) reads 0x87, so control & 0x17 = 0x07 and bits [7:5] = 100 (configuration). Status (0x0E) reads 0x80. `irq_n` is high.
- R2: Opcode 0x03 followed by an address returns that register's data on MISO from the third byte onward, MSB first. Each further byte returns the next address.
- R3: Opcode 0x02 followed by an address writes each following byte to that address and then to the successive addresses.
- R4: During sequential read or write, the address advances from 0x7F to 0x00.
- R5: Opcode 0x05 is followed by address, mask and data bytes. Only the register bits set in the mask take the data value; all other bits keep their value.
- R6: Opcodes 0x40, 0x42 and 0x44 load transmit buffer n = 0, 1, 2. The following bytes are written starting at 0x31 + 0x10·n, and the buffer's control byte at 0x30 + 0x10·n is untouched.
- R7: Opcodes 0x90 and 0x94 read receive buffer n = 0 and n = 1. The second byte of the transfer returns address 0x61 + 0x10·n, and successive bytes follow, up to a 14-byte transfer.
- R8: When chip select rises after a 0x90 or 0x94 transfer, flag bit n of register 0x2C is cleared and all other flag bits are kept. A plain 0x03 read of the same addresses clears nothing.
- R9: Status bits [7:5] show control bits [7:5] (000 normal, 001 sleep, 010 loopback, 011 listen-only, 100 configuration) one clock after control is written. Status bits [4:0] read 0, and writes to 0x0E are ignored.
- R10: `irq_n` is low exactly while (enable register 0x2B & flag register 0x2C) is non-zero. In the flag register, bit 0 means receive buffer 0 full, bit 1 receive buffer 1 full, bits 2/3/4 transmit buffer 0/1/2 done, bit 5 error, bit 6 wake-up and bit 7 message error.
- R11: Opcodes outside the set above, including 0x46 and 0x92, change no register for the rest of that transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCLK is oversampled by it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, changes after SCLK falls |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The main access paths are tried with three kinds of pattern. The first is one 130-byte write burst that starts at 0x30 and wraps past 0x7F. It is followed by a full 128-byte read burst starting mid-space, which together tell apart correct address stepping, wrap, and the read-only status byte from off-by-one and stuck-pointer faults. The second is a set of bit-modify masks (none, all, alternating, nibble, end bits) that separates masked merge from plain write. The third is a run of the buffer shortcuts for each index, which shows whether the start address is implied correctly and whether only the right flag bit is cleared. A mode sweep through all five requests and enable/flag combinations on the interrupt pin round this out.

// File: rtl/spi_regcmd_pkg.sv
package spi_regcmd_pkg;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_BITMOD = 8'h05;
  localparam logic [7:0] OP_RESET  = 8'hC0;

  localparam logic [7:0] CTRL_RST = 8'h87;
  localparam logic [7:0] STAT_RST = 8'h80;

  typedef enum logic [2:0] {
    SQ_OPC, SQ_ADDR, SQ_WR, SQ_RD, SQ_MASK, SQ_MDAT, SQ_HALT
  } seq_st_e;

  typedef enum logic [1:0] {
    AC_READ, AC_WRITE, AC_BITMOD
  } acc_kind_e;

  // masked merge: bits set in mask take new data
  function automatic logic [7:0] bit_merge(input logic [7:0] old_v,
                                           input logic [7:0] mask,
                                           input logic [7:0] data);
    return (old_v & ~mask) | (data & mask);
  endfunction

  // first byte after a transmit buffer's control byte
  function automatic logic [7:0] txb_start(input logic [1:0] idx);
    return 8'h31 + {2'b00, idx, 4'h0};
  endfunction

  function automatic logic [7:0] rxb_start(input logic idx);
    return 8'h61 + {3'b000, idx, 4'h0};
  endfunction

  function automatic logic is_txb_op(input logic [7:0] op, input int ntx);
    return (op[7:3] == 5'b01000) && (op[0] == 1'b0) && (int'(op[2:1]) < ntx);
  endfunction

  function automatic logic is_rxb_op(input logic [7:0] op, input int nrx);
    return (op[7:3] == 5'b10010) && (op[1:0] == 2'b00) && (int'(op[2]) < nrx);
  endfunction

endpackage

// File: rtl/spi_regcmd_shift.sv
module spi_regcmd_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            cs_n,
  input  logic            mosi,
  input  logic [BITS-1:0] tx_byte,
  output logic            miso,
  output logic            rx_valid,
  output logic [BITS-1:0] rx_byte,
  output logic            tx_load,
  output logic            cs_active,
  output logic            cs_rise
);
  localparam int CNT_W = $clog2(BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  logic [1:0] sclk_s, cs_s, mosi_s;
  logic       sclk_d, cs_d;
  logic [CNT_W-1:0] bit_cnt;
  logic [BITS-1:0]  in_sh, out_sh;
  logic             miso_q;
  logic             sclk_rise, sclk_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0; cs_s <= 2'b11; mosi_s <= '0;
      sclk_d <= 1'b0; cs_d <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[0], sclk};
      cs_s   <= {cs_s[0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
      sclk_d <= sclk_s[1];
      cs_d   <= cs_s[1];
    end
  end

  assign cs_active = ~cs_s[1];
  assign cs_rise   = cs_s[1] & ~cs_d;
  assign sclk_rise = cs_active & sclk_s[1] & ~sclk_d;
  assign sclk_fall = cs_active & ~sclk_s[1] & sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0; in_sh <= '0; out_sh <= '0; miso_q <= 1'b0;
      rx_valid <= 1'b0; rx_byte <= '0; tx_load <= 1'b0;
    end else if (!cs_active) begin
      bit_cnt <= '0; rx_valid <= 1'b0; tx_load <= 1'b0; miso_q <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      if (sclk_rise) begin
        in_sh   <= {in_sh[BITS-2:0], mosi_s[1]};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          rx_valid <= 1'b1;
          rx_byte  <= {in_sh[BITS-2:0], mosi_s[1]};
        end
      end
      if (sclk_fall) begin
        if (bit_cnt == '0) begin
          miso_q  <= tx_byte[BITS-1];
          out_sh  <= {tx_byte[BITS-2:0], 1'b0};
          tx_load <= 1'b1;
        end else begin
          miso_q <= out_sh[BITS-1];
          out_sh <= {out_sh[BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign miso = miso_q;

  // R2
  rx_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R2
  rx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(cs_active));

endmodule

// File: rtl/spi_regcmd_seq.sv
module spi_regcmd_seq
  import spi_regcmd_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int NUM_TXB = 3,
  parameter int NUM_RXB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              cs_rise,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_load,
  input  logic [7:0]        rdata,
  output logic [7:0]        tx_byte,
  output logic [ADDR_W-1:0] raddr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wdata,
  output logic [7:0]        wmask,
  output logic              srst,
  output logic [7:0]        clr_mask
);
  seq_st_e          st;
  acc_kind_e        kind;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]       mask_q;
  logic             rx_pend, rx_idx;
  logic [7:0]       tx_base, rx_base;

  always_comb begin
    tx_base = txb_start(rx_byte[2:1]);
    rx_base = rxb_start(rx_byte[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_OPC; kind <= AC_READ; ptr <= '0; mask_q <= '0;
      rx_pend <= 1'b0; rx_idx <= 1'b0;
      we <= 1'b0; waddr <= '0; wdata <= '0; wmask <= '0;
      srst <= 1'b0; clr_mask <= '0;
    end else begin
      we <= 1'b0; srst <= 1'b0; clr_mask <= '0;
      if (!cs_active) begin
        st <= SQ_OPC;
        if (cs_rise && rx_pend) clr_mask <= 8'(1) << rx_idx;
        rx_pend <= 1'b0;
      end else if (rx_valid) begin
        unique case (st)
          SQ_OPC: begin
            st <= SQ_HALT;
            if (rx_byte == OP_READ) begin
              kind <= AC_READ; st <= SQ_ADDR;
            end else if (rx_byte == OP_WRITE) begin
              kind <= AC_WRITE; st <= SQ_ADDR;
            end else if (rx_byte == OP_BITMOD) begin
              kind <= AC_BITMOD; st <= SQ_ADDR;
            end else if (rx_byte == OP_RESET) begin
              srst <= 1'b1;
            end else if (is_txb_op(rx_byte, NUM_TXB)) begin
              ptr <= tx_base[ADDR_W-1:0]; st <= SQ_WR;
            end else if (is_rxb_op(rx_byte, NUM_RXB)) begin
              ptr <= rx_base[ADDR_W-1:0]; st <= SQ_RD;
              rx_pend <= 1'b1; rx_idx <= rx_byte[2];
            end
          end
          SQ_ADDR: begin
            ptr <= rx_byte[ADDR_W-1:0];
            unique case (kind)
              AC_READ:  st <= SQ_RD;
              AC_WRITE: st <= SQ_WR;
              default:  st <= SQ_MASK;
            endcase
          end
          SQ_WR: begin
            we <= 1'b1; waddr <= ptr; wdata <= rx_byte; wmask <= 8'hFF;
            ptr <= ptr + 1'b1;
          end
          SQ_MASK: begin
            mask_q <= rx_byte; st <= SQ_MDAT;
          end
          SQ_MDAT: begin
            we <= 1'b1; waddr <= ptr; wdata <= rx_byte; wmask <= mask_q;
            st <= SQ_HALT;
          end
          default: ;
        endcase
      end else if (tx_load && st == SQ_RD) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  assign raddr   = ptr;
  assign tx_byte = (st == SQ_RD) ? rdata : 8'h00;

  // R8
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we, srst, |clr_mask}));

endmodule

// File: rtl/spi_regcmd_bank.sv
module spi_regcmd_bank
  import spi_regcmd_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int STAT_ADDR = 14,
  parameter int CTRL_ADDR = 15,
  parameter int IEN_ADDR  = 43,
  parameter int IFLG_ADDR = 44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        wmask,
  input  logic [7:0]        clr_mask,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata,
  output logic              irq_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] STAT_A = STAT_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CTRL_A = CTRL_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] IEN_A  = IEN_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] IFLG_A = IFLG_ADDR[ADDR_W-1:0];

  logic [7:0] mem [DEPTH];
  logic [7:0] ctrl_q, stat_q, ien_q, iflg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i[ADDR_W-1:0]] <= '0;
      mem[CTRL_A] <= CTRL_RST;
      mem[STAT_A] <= STAT_RST;
    end else if (srst) begin
      for (int i = 0; i < DEPTH; i++) mem[i[ADDR_W-1:0]] <= '0;
      mem[CTRL_A] <= CTRL_RST;
      mem[STAT_A] <= STAT_RST;
    end else begin
      if (we && waddr != STAT_A) mem[waddr] <= bit_merge(mem[waddr], wmask, wdata);
      mem[STAT_A] <= {mem[CTRL_A][7:5], 5'b00000};
      if (|clr_mask) mem[IFLG_A] <= mem[IFLG_A] & ~clr_mask;
    end
  end

  assign ctrl_q = mem[CTRL_A];
  assign stat_q = mem[STAT_A];
  assign ien_q  = mem[IEN_A];
  assign iflg_q = mem[IFLG_A];
  assign rdata  = mem[raddr];
  assign irq_n  = ~|(ien_q & iflg_q);

  // R1
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (ctrl_q == CTRL_RST) && (stat_q == STAT_RST));

  // R5
  masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !srst && waddr != STAT_A && clr_mask == 8'h00)
      |=> ((mem[$past(waddr)] & $past(wmask)) == ($past(wdata) & $past(wmask))));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask && !srst) |=> ((iflg_q & $past(clr_mask)) == 8'h00));

  // R9
  stat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == STAT_A && !srst) |=> (stat_q[4:0] == 5'b00000));

endmodule

// File: rtl/can_spi_cmd_slave.sv
module can_spi_cmd_slave #(
  parameter int ADDR_W  = 7,
  parameter int NUM_TXB = 3,
  parameter int NUM_RXB = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic irq_n
);
  logic              cs_active, cs_rise, rx_valid, tx_load;
  logic [7:0]        rx_byte, tx_byte, rdata, wdata, wmask, clr_mask;
  logic [ADDR_W-1:0] raddr, waddr;
  logic              we, srst;

  spi_regcmd_shift #(.BITS(8)) shift_i (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_byte(tx_byte), .miso(spi_miso), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_load(tx_load), .cs_active(cs_active), .cs_rise(cs_rise)
  );

  spi_regcmd_seq #(.ADDR_W(ADDR_W), .NUM_TXB(NUM_TXB), .NUM_RXB(NUM_RXB)) seq_i (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .cs_rise(cs_rise),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_load(tx_load), .rdata(rdata),
    .tx_byte(tx_byte), .raddr(raddr), .we(we), .waddr(waddr), .wdata(wdata),
    .wmask(wmask), .srst(srst), .clr_mask(clr_mask)
  );

  spi_regcmd_bank #(.ADDR_W(ADDR_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .srst(srst), .we(we), .waddr(waddr),
    .wdata(wdata), .wmask(wmask), .clr_mask(clr_mask), .raddr(raddr),
    .rdata(rdata), .irq_n(irq_n)
  );

endmodule

// File: tb/can_spi_cmd_slave_tb_top.sv
module can_spi_cmd_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, irq_n;
  int nchk = 0, nerr = 0;
  logic [7:0] tb_tx [0:159];
  logic [7:0] tb_rx [0:159];
  logic [7:0] m [0:127];

  always #5 clk = ~clk;

  can_spi_cmd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    return (a == 14) ? {m[15][7:5], 5'b00000} : m[a];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 128; i++) m[i] = 8'h00;
    m[15] = 8'h87;
  endtask

  task automatic spi_run(input int n);
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      for (int k = 7; k >= 0; k--) begin
        mosi = tb_tx[b][k];
        repeat (8) @(negedge clk);
        tb_rx[b][k] = miso;
        sclk = 1'b1;
        repeat (8) @(negedge clk);
        sclk = 1'b0;
      end
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  // payload already in tb_tx[2..n+1]
  task automatic do_write(input int a, input int n);
    tb_tx[0] = 8'h02; tb_tx[1] = 8'(a);
    spi_run(n + 2);
    for (int i = 0; i < n; i++) if (((a + i) % 128) != 14) m[(a + i) % 128] = tb_tx[2 + i];
  endtask

  task automatic wr1(input int a, input logic [7:0] d);
    tb_tx[2] = d;
    do_write(a, 1);
  endtask

  task automatic read_chk(input string req, input int a, input int n);
    tb_tx[0] = 8'h03; tb_tx[1] = 8'(a);
    for (int i = 2; i < n + 2; i++) tb_tx[i] = 8'h00;
    spi_run(n + 2);
    for (int i = 0; i < n; i++) check(req, tb_rx[2 + i], exp_rd((a + i) % 128));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] masks [0:4];
    masks[0] = 8'h00; masks[1] = 8'hFF; masks[2] = 8'hA5; masks[3] = 8'h3C; masks[4] = 8'h81;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, whole space
    check("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
    read_chk("R1 reset contents", 0, 128);

    // R3/R4 burst write wrapping past 0x7F, R2 burst read
    for (int i = 0; i < 130; i++) tb_tx[2 + i] = 8'((i * 37 + 11) & 255);
    do_write(8'h30, 130);
    read_chk("R2 R4 burst read", 8'h50, 128);
    check("R10 irq after burst", {7'b0, irq_n}, {7'b0, ~|(m[43] & m[44])});

    // R1 soft reset opcode
    tb_tx[0] = 8'hC0; spi_run(1);
    model_reset();
    read_chk("R1 after 0xC0", 0, 128);
    check("R1 irq_n after 0xC0", {7'b0, irq_n}, 8'h01);

    // R5 bit modify sweep
    wr1(8'h20, 8'h96);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] d;
      d = 8'(8'h5A ^ (k * 8'h33));
      tb_tx[0] = 8'h05; tb_tx[1] = 8'h20; tb_tx[2] = masks[k]; tb_tx[3] = d;
      spi_run(4);
      m[32] = (m[32] & ~masks[k]) | (d & masks[k]);
      read_chk("R5 bit modify", 8'h20, 1);
    end

    // R9 mode request sweep and read-only status
    for (int md = 0; md < 5; md++) begin
      wr1(15, 8'(md << 5) | 8'h07);
      read_chk("R9 mode status", 14, 2);
    end
    wr1(14, 8'hFF);
    read_chk("R9 status write ignored", 14, 1);

    // R6 transmit buffer loads
    for (int n = 0; n < 3; n++) begin
      tb_tx[0] = 8'(8'h40 + 2 * n);
      for (int i = 1; i < 14; i++) tb_tx[i] = 8'(n * 16 + i + 8'hA0);
      spi_run(14);
      for (int i = 1; i < 14; i++) m[16 * n + 16'h30 + i] = tb_tx[i];
      read_chk("R6 tx buffer load", 16 * n + 8'h30, 14);
    end

    // R7 R8 R10 receive buffer reads
    for (int n = 0; n < 2; n++) begin
      for (int i = 0; i < 13; i++) tb_tx[2 + i] = 8'(n * 8'h40 + i * 5 + 1);
      do_write(16 * n + 8'h61, 13);
    end
    tb_tx[2] = 8'h03; tb_tx[3] = 8'h03; do_write(8'h2B, 2);
    check("R10 irq low with flags", {7'b0, irq_n}, 8'h00);
    read_chk("R8 plain read", 8'h61, 4);
    read_chk("R8 flags kept after plain read", 8'h2C, 1);
    for (int n = 0; n < 2; n++) begin
      tb_tx[0] = (n == 0) ? 8'h90 : 8'h94;
      for (int i = 1; i < 14; i++) tb_tx[i] = 8'h00;
      spi_run(14);
      for (int i = 1; i < 14; i++) check("R7 rx buffer read", tb_rx[i], m[16 * n + 8'h61 + i - 1]);
      m[44] = m[44] & ~8'(1 << n);
      read_chk("R8 flag cleared", 8'h2C, 1);
      check("R10 irq follows flags", {7'b0, irq_n}, (n == 0) ? 8'h00 : 8'h01);
    end
    wr1(8'h2B, 8'h00); wr1(8'h2C, 8'h80);
    check("R10 flag but disabled", {7'b0, irq_n}, 8'h01);
    wr1(8'h2B, 8'h80);
    check("R10 message error enabled", {7'b0, irq_n}, 8'h00);
    wr1(8'h2C, 8'h00);
    check("R10 cleared", {7'b0, irq_n}, 8'h01);

    // R11 unknown opcodes
    tb_tx[0] = 8'h46; for (int i = 1; i < 8; i++) tb_tx[i] = 8'hEE;
    spi_run(8);
    tb_tx[0] = 8'h92; spi_run(8);
    tb_tx[0] = 8'h77; spi_run(8);
    read_chk("R11 unknown opcode ignored", 8'h60, 32);
    read_chk("R11 low space intact", 0, 48);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule